// File: doc/BRIEF.md
# Byte and Word FIFO Data Port

This block is the data side of a serial controller's register interface. It holds a transmit FIFO and a receive FIFO, each with byte-wide entries, behind a 32-bit host bus. The host moves data through four addresses. One pair transfers a single byte per access. The other pair transfers four bytes per access, with the lowest byte lane always first in stream order. The serial engine that drains the transmit FIFO and fills the receive FIFO connects through two plain valid/ready byte streams.

Software polls a status word before each transfer. It can test whether data is waiting, whether the receive side is empty, and whether the transmit side is full. A control flag selects four-byte flag behaviour. In that mode the empty and full indications are computed against a four-byte unit, so that a single poll is enough to guard a word access. The flag's state also appears in the status word.

Top module: `fifo_data_port`

## Requirements
- R1: After reset both FIFOs are empty, `ser_tx_valid` is 0, `bus_rdata` is 0 and the status word at offset 0x10 reads 0x99.
- R2: A write to offset 0x44 appends `bus_wdata[7:0]` to the transmit FIFO, and the bytes leave on `ser_tx_data` in the order written.
- R3: A write to offset 0x4C appends four bytes: bits 7:0 first, then 15:8, then 23:16, then 31:24.
- R4: A read of offset 0x40 pops the oldest received byte and returns it in bits 7:0 with the upper bits zero. The data is on `bus_rdata` one clock after the access.
- R5: A read of offset 0x48 pops four bytes and returns them with the oldest in bits 7:0 and the newest in bits 31:24.
- R6: Bit 16 of the control word at offset 0x00 selects four-byte mode. It reads back at offset 0x00 and is mirrored in status bit 8.
- R7: The status bits are: 0 transmit FIFO empty, 1 receive FIFO full, 2 receive-available (the inverse of bit 4), 3 transmit-available (the inverse of bit 5), 4 receive-empty, 5 transmit-full, 6 zero, 7 ready (both FIFOs empty), 8 four-byte mode. With the mode clear, bit 4 means no entries and bit 5 means no free slots.
- R8: With four-byte mode set, receive-empty reads 1 while fewer than four bytes are held, and transmit-full reads 1 while fewer than four slots are free.
- R9: A byte read of an empty receive FIFO, or a word read while fewer than four bytes are held, returns zero and pops nothing.
- R10: A byte write to a full transmit FIFO, or a word write while fewer than four slots are free, is dropped whole.
- R11: `ser_rx_ready` is 0 exactly when the receive FIFO is full. A byte offered on `ser_tx_data` stays stable until it is accepted. Neither FIFO count exceeds the depth.
- R12: A host pop and an engine push on the receive FIFO in the same cycle are both applied, and no byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Host access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ser_tx_data | output | 8 | Byte to the serial engine |
| ser_tx_valid | output | 1 | Transmit byte available |
| ser_tx_ready | input | 1 | Engine accepts the transmit byte |
| ser_rx_data | input | 8 | Byte from the serial engine |
| ser_rx_valid | input | 1 | Received byte offered |
| ser_rx_ready | output | 1 | Receive FIFO can accept a byte |

## Verification
The receive FIFO can be popped by the host and pushed by the serial engine in the same clock. The count must then take both changes, including a four-byte pop that meets a one-byte push. The bench provokes this by starting an engine push and a host byte or word read on the same clock edge. It then reads every remaining byte back, so that any lost or duplicated entry shows up as a data mismatch or a wrong empty result. On the transmit side, the engine drains bytes while host writes continue, and the bench compares each drained byte against its ordered queue.

// File: rtl/fifo_data_port.sv
module fifo_data_port #(
  parameter int DEPTH = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [7:0]    ser_tx_data,
  output logic          ser_tx_valid,
  input  logic          ser_tx_ready,
  input  logic [7:0]    ser_rx_data,
  input  logic          ser_rx_valid,
  output logic          ser_rx_ready
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h10);
  localparam logic [AW-1:0] A_RXB  = AW'(8'h40);
  localparam logic [AW-1:0] A_TXB  = AW'(8'h44);
  localparam logic [AW-1:0] A_RXW  = AW'(8'h48);
  localparam logic [AW-1:0] A_TXW  = AW'(8'h4C);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] FOUR   = CW'(4);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          x4;

  logic wr, rd;
  assign wr = bus_en &  bus_we;
  assign rd = bus_en & ~bus_we;

  logic [CW-1:0] tx_free;
  assign tx_free = FULL - tx_cnt;

  logic tx_wr_b, tx_wr_w, tx_pop;
  assign tx_wr_b = wr && bus_addr == A_TXB && tx_cnt != FULL;
  assign tx_wr_w = wr && bus_addr == A_TXW && tx_free >= FOUR;
  assign tx_pop  = ser_tx_valid & ser_tx_ready;

  logic rx_rd_b, rx_rd_w, rx_push;
  assign rx_rd_b = rd && bus_addr == A_RXB && rx_cnt != '0;
  assign rx_rd_w = rd && bus_addr == A_RXW && rx_cnt >= FOUR;
  assign rx_push = ser_rx_valid & ser_rx_ready;

  assign ser_tx_valid = tx_cnt != '0;
  assign ser_tx_data  = tx_mem[tx_rp];
  assign ser_rx_ready = rx_cnt != FULL;

  logic [CW-1:0] tx_add, rx_sub;
  assign tx_add = tx_wr_b ? CW'(1) : (tx_wr_w ? FOUR : '0);
  assign rx_sub = rx_rd_b ? CW'(1) : (rx_rd_w ? FOUR : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
      x4     <= 1'b0;
    end else begin
      if (tx_wr_b)      tx_wp <= tx_wp + PW'(1);
      else if (tx_wr_w) tx_wp <= tx_wp + PW'(4);
      if (tx_pop)       tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + tx_add - CW'(tx_pop);
      if (rx_push)      rx_wp <= rx_wp + PW'(1);
      if (rx_rd_b)      rx_rp <= rx_rp + PW'(1);
      else if (rx_rd_w) rx_rp <= rx_rp + PW'(4);
      rx_cnt <= rx_cnt + CW'(rx_push) - rx_sub;
      if (wr && bus_addr == A_CTRL) x4 <= bus_wdata[16];
    end

  always_ff @(posedge clk)
    if (tx_wr_b)
      tx_mem[tx_wp] <= bus_wdata[7:0];
    else if (tx_wr_w)
      for (int k = 0; k < 4; k++)
        tx_mem[tx_wp + PW'(k)] <= bus_wdata[8*k +: 8];

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= ser_rx_data;

  logic rx_empty_f, tx_full_f, tx_done, rx_done, ready;
  assign rx_empty_f = x4 ? (rx_cnt < FOUR)  : (rx_cnt == '0);
  assign tx_full_f  = x4 ? (tx_free < FOUR) : (tx_cnt == FULL);
  assign tx_done    = tx_cnt == '0;
  assign rx_done    = rx_cnt == FULL;
  assign ready      = tx_done && rx_cnt == '0;

  logic [31:0] status;
  assign status = {23'd0, x4, ready, 1'b0, tx_full_f, rx_empty_f,
                   ~tx_full_f, ~rx_empty_f, rx_done, tx_done};

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    unique case (bus_addr)
      A_CTRL:  rd_val = {15'd0, x4, 16'd0};
      A_STAT:  rd_val = status;
      A_RXB:   if (rx_rd_b) rd_val = {24'd0, rx_mem[rx_rp]};
      A_RXW:   if (rx_rd_w) rd_val = {rx_mem[rx_rp + PW'(3)], rx_mem[rx_rp + PW'(2)],
                                      rx_mem[rx_rp + PW'(1)], rx_mem[rx_rp]};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
endmodule

module fifo_data_port_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = 8,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic [7:0]    ser_tx_data,
  input logic          ser_tx_valid,
  input logic          ser_tx_ready,
  input logic          ser_rx_valid,
  input logic          ser_rx_ready,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  localparam logic [AW-1:0] RXB = AW'(8'h40);
  localparam logic [AW-1:0] TXB = AW'(8'h44);
  localparam logic [AW-1:0] RXW = AW'(8'h48);

  logic host_rx_rd;
  assign host_rx_rd = bus_en && !bus_we && (bus_addr == RXB || bus_addr == RXW);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_tx_valid && !ser_tx_ready) |=> (ser_tx_valid && $stable(ser_tx_data)));

  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && ((bus_addr == RXB && rx_cnt == '0) ||
                           (bus_addr == RXW && rx_cnt < CW'(4)))) |=> bus_rdata == 32'd0);

  a_r10_full_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == TXB && tx_cnt == CW'(DEPTH) &&
     !(ser_tx_valid && ser_tx_ready)) |=> tx_cnt == CW'(DEPTH));

  a_r12_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_valid && ser_rx_ready && !host_rx_rd) |=> rx_cnt == $past(rx_cnt) + CW'(1));
endmodule

bind fifo_data_port fifo_data_port_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
  .ser_tx_ready(ser_tx_ready), .ser_rx_valid(ser_rx_valid), .ser_rx_ready(ser_rx_ready),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/test_fifo_data_port.sv
module test_fifo_data_port;
  localparam int DEPTH = 32;
  localparam int AW    = 8;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] ser_tx_data, ser_rx_data = '0;
  logic ser_tx_valid, ser_tx_ready = 0, ser_rx_valid = 0, ser_rx_ready;

  fifo_data_port #(.DEPTH(DEPTH), .AW(AW)) i_fifo_data_port (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [31:0] rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (ser_tx_valid && ser_tx_ready) begin
      if (txq.size() == 0) chk(0, "R2 R3 unexpected tx byte", ser_tx_data, 0);
      else begin
        logic [7:0] e;
        e = txq.pop_front();
        chk(ser_tx_data == e, "R2 R3 tx byte order", ser_tx_data, e);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h44 && txq.size() < DEPTH) txq.push_back(d[7:0]);
    if (a == 8'h4C && DEPTH - txq.size() >= 4)
      for (int k = 0; k < 4; k++) txq.push_back(d[8*k +: 8]);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_byte();
    if (rxq.size() == 0) return 0;
    return {24'd0, rxq.pop_front()};
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] v = 0;
    if (rxq.size() < 4) return 0;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = rxq.pop_front();
    return v;
  endfunction

  task automatic rd_byte(input string tag);
    logic [31:0] e, d;
    e = exp_byte();
    bus_rd(8'h40, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic rd_word(input string tag);
    logic [31:0] e, d;
    e = exp_word();
    bus_rd(8'h48, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    ser_rx_valid = 1; ser_rx_data = b;
    #1;
    if (ser_rx_ready) rxq.push_back(b);
    @(negedge clk);
    ser_rx_valid = 0;
  endtask

  task automatic stat(input logic [31:0] e, input string tag);
    bus_rd(8'h10, rd);
    chk(rd == e, tag, rd, e);
  endtask

  bit done = 0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ser_tx_valid == 0, "R1 tx valid", ser_tx_valid, 0);
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    stat(32'h99, "R1 status");

    bus_wr(8'h44, 32'hFFFF_FFA1);
    bus_wr(8'h44, 32'h0000_00B2);
    bus_wr(8'h4C, 32'h4433_2211);
    stat(32'h18, "R7 status with tx data");
    chk(ser_tx_valid && ser_tx_data == 8'hA1, "R11 tx head held", ser_tx_data, 8'hA1);
    ser_tx_ready = 1;
    repeat (12) @(negedge clk);
    chk(txq.size() == 0, "R2 R3 tx drained", txq.size(), 0);
    ser_tx_ready = 0;

    for (int i = 0; i < 5; i++) rx_push(8'h10 + 8'(i));
    stat(32'h0D, "R7 status with rx data");
    rd_word("R5 word read");
    rd_byte("R4 byte read");
    rd_byte("R9 empty byte read");
    rx_push(8'h51); rx_push(8'h52);
    rd_word("R9 short word read");
    rd_byte("R9 no pop first");
    rd_byte("R9 no pop second");

    rx_push(8'h21); rx_push(8'h22);
    fork
      rx_push(8'h23);
      rd_byte("R12 byte pop with push");
    join
    rd_byte("R12 after pop 1");
    rd_byte("R12 after pop 2");
    rd_byte("R12 empty after");
    for (int i = 0; i < 4; i++) rx_push(8'h60 + 8'(i));
    fork
      rx_push(8'h64);
      rd_word("R12 word pop with push");
    join
    rd_byte("R12 fifth byte");
    rd_byte("R12 empty again");

    bus_wr(8'h00, 32'h0001_0000);
    bus_rd(8'h00, rd);
    chk(rd == 32'h0001_0000, "R6 control readback", rd, 32'h0001_0000);
    for (int i = 0; i < 3; i++) rx_push(8'h70 + 8'(i));
    stat(32'h119, "R8 rx three bytes");
    rx_push(8'h73);
    stat(32'h10D, "R8 rx four bytes");
    rd_word("R5 word read in four-byte mode");

    for (int i = 0; i < 29; i++) bus_wr(8'h44, 32'(i));
    stat(32'h130, "R8 tx three free");
    bus_wr(8'h00, 32'h0);
    stat(32'h18, "R7 tx three free normal");
    bus_wr(8'h4C, 32'hDEAD_BEEF);
    stat(32'h18, "R10 word write dropped");
    for (int i = 0; i < 3; i++) bus_wr(8'h44, 32'hC0 + 32'(i));
    stat(32'h30, "R7 tx full");
    bus_wr(8'h44, 32'hEE);
    chk(ser_tx_data == 8'h00, "R11 tx head while full", ser_tx_data, 0);
    ser_tx_ready = 1;
    repeat (40) @(negedge clk);
    chk(txq.size() == 0 && !ser_tx_valid, "R10 dropped byte absent", ser_tx_valid, 0);
    ser_tx_ready = 0;

    for (int i = 0; i < DEPTH; i++) rx_push(8'h80 + 8'(i));
    chk(ser_rx_ready == 0, "R11 rx ready low when full", ser_rx_ready, 0);
    stat(32'h0F, "R7 rx full");
    rx_push(8'hFE);
    chk(rxq.size() == DEPTH, "R11 extra push refused", rxq.size(), DEPTH);
    for (int i = 0; i < DEPTH / 4; i++) rd_word("R5 drain full fifo");
    rd_word("R9 drained word read");
    stat(32'h99, "R7 idle at end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule